// File: doc/BRIEF.md
# Quad-Word Page Programming Sequencer

This block runs the fast multi-page programming flow of a flash-style memory. It is armed by a one-cycle `start` pulse from the command decoder, which sits outside it. From then on it accepts plain bus writes. Each page is exactly four data words. The words are gathered into a buffer and then handed to an external program/verify engine through a request/done/pass handshake. When a page passes, the block waits for the first word of the next page in the same block.

The first write of the command fixes the start address. That address sets the block being programmed, which is its upper address bits, and it is also the base of the first page. An internal page pointer follows the pages written at the start address. A failed verify is retried a limited number of times; when the retries run out, an error flag is raised. The flow ends when a first-word write carrying all-ones data targets an address outside the block.

An 8-bit status byte reports the phase. Bit 7 reads 1 when ready. Bit 0 reads 1 while program/verify is running. Bit 4 is the error flag.

Top module: `quadword_prog_seq`

## Requirements
- R1: After reset the status byte reads 0x80: bit 7 (ready) is 1, bit 0 (program/verify busy) is 0, bit 4 (error) is 0, and all other bits are 0.
- R2: A `start` pulse while ready enters the flow, and bit 7 reads 0 from the next cycle until the flow exits. A `start` pulse while the flow is active is ignored.
- R3: The first bus write after `start` latches its address as the start address and its data as word 0. The first page's base (`pv_addr`) is the start address. The block is the address bits above the lowest BLK_BITS bits.
- R4: A page takes exactly four bus writes, with no early exit. Word k appears at `pv_data[k*DATA_W +: DATA_W]`. For words 1 to 3 the address is ignored and any data is taken, including all-ones written outside the block.
- R5: On the clock edge that takes the fourth word, `pv_req` goes high for one cycle and the status reads 0x01.
- R6: Bus writes made while program/verify runs are ignored. `pv_data` and the status do not change, including when such a write coincides with `pv_done`.
- R7: `pv_done` with `pv_pass`=1 returns the status to 0x00 (awaiting the next page). It also advances the page pointer by four words, wrapping inside the block.
- R8: The first write of a later page at exactly the start address uses the page pointer as the base. At any other address inside the block it uses that address as the base.
- R9: A first-word write outside the block with data all-ones ends the flow, and the status reads 0x80. A first-word write outside the block with any other data is ignored.
- R10: `pv_done` with `pv_pass`=0 pulses `pv_req` again, up to MAX_RETRY times per page. A failure after that sets the error bit and ends the flow, and the status reads 0x90.
- R11: The error bit stays set while ready, including across bus writes. The next accepted `start` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that enters the programming flow |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Bus write word address |
| wr_data | input | DATA_W | Bus write data |
| pv_req | output | 1 | One-cycle program/verify request |
| pv_addr | output | ADDR_W | Base word address of the page being programmed |
| pv_data | output | 4*DATA_W | The four page words, word 0 in the low bits |
| pv_done | input | 1 | Program/verify attempt finished |
| pv_pass | input | 1 | Attempt result, valid with pv_done |
| status | output | 8 | Status byte: bit 7 ready, bit 4 error, bit 0 program/verify busy |

## Verification
A bus write can land in the very cycle that the engine reports `pv_done`. The completion must then be taken while the write is dropped. The bench provokes this by driving `wr_en` with a different data word in the same cycle as a passing `pv_done`. It judges the result by checking that the status falls to 0x00 while `pv_data` keeps the page that was programmed. Randomly chosen page addresses, data and retry counts are compared against a bench model of the page pointer and the block check.

// File: rtl/qpp_pkg.sv
package qpp_pkg;

    localparam int PAGE_WORDS = 4;
    localparam int SR_READY   = 7;
    localparam int SR_ERR     = 4;
    localparam int SR_PVBUSY  = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRST,
        ST_LOAD,
        ST_WAIT,
        ST_PV
    } qpp_state_e;

    typedef struct packed {
        logic ready;
        logic err;
        logic pvbusy;
    } qpp_flags_t;

    function automatic logic [7:0] status_code(input qpp_flags_t f);
        logic [7:0] s;
        s            = '0;
        s[SR_READY]  = f.ready;
        s[SR_ERR]    = f.err;
        s[SR_PVBUSY] = f.pvbusy;
        return s;
    endfunction

endpackage

// File: rtl/qpp_addr_gen.sv
module qpp_addr_gen #(
    parameter int ADDR_W   = 16,
    parameter int BLK_BITS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              latch_start,
    input  logic              latch_page,
    input  logic              adv,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              in_blk,
    output logic [ADDR_W-1:0] page_base
);
    localparam logic [BLK_BITS-1:0] STEP = BLK_BITS'(qpp_pkg::PAGE_WORDS);

    logic [ADDR_W-1:0] start_q, ptr_q, base_q;
    logic              hit_start;

    assign in_blk    = wr_addr[ADDR_W-1:BLK_BITS] == start_q[ADDR_W-1:BLK_BITS];
    assign hit_start = wr_addr == start_q;
    assign page_base = base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            ptr_q   <= '0;
            base_q  <= '0;
        end else if (latch_start) begin
            start_q <= wr_addr;
            ptr_q   <= wr_addr;
            base_q  <= wr_addr;
        end else begin
            if (latch_page)
                base_q <= hit_start ? ptr_q : wr_addr;
            if (adv)
                ptr_q <= {ptr_q[ADDR_W-1:BLK_BITS], ptr_q[BLK_BITS-1:0] + STEP};
        end
    end
endmodule

// File: rtl/qpp_page_buf.sv
module qpp_page_buf #(
    parameter int DATA_W = 16,
    parameter int WORDS  = 4,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [IDX_W-1:0]        idx,
    input  logic [DATA_W-1:0]       din,
    output logic [WORDS*DATA_W-1:0] page
);
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst)
                word_q <= '0;
            else if (we && idx == IDX_W'(g))
                word_q <= din;
        end
        assign page[g*DATA_W +: DATA_W] = word_q;
    end
endmodule

// File: rtl/qpp_ctrl.sv
module qpp_ctrl
    import qpp_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int MAX_RETRY = 2,
    localparam int IDX_W    = $clog2(PAGE_WORDS),
    localparam int RW       = $clog2(MAX_RETRY + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              in_blk,
    input  logic              pv_done,
    input  logic              pv_pass,
    output logic              latch_start,
    output logic              latch_page,
    output logic              buf_we,
    output logic [IDX_W-1:0]  buf_idx,
    output logic              adv,
    output logic              pv_req,
    output logic [7:0]        status
);
    qpp_state_e       st_q;
    logic [IDX_W-1:0] idx_q;
    logic [RW-1:0]    retry_q;
    logic             err_q, req_q;
    logic             term, last_word, pv_ok, pv_bad;
    qpp_flags_t       flags;

    always_comb begin
        latch_start = wr_en && st_q == ST_FIRST;
        latch_page  = wr_en && st_q == ST_WAIT && in_blk;
        term        = wr_en && st_q == ST_WAIT && !in_blk && (&wr_data);
        buf_we      = latch_start || latch_page || (wr_en && st_q == ST_LOAD);
        buf_idx     = (st_q == ST_LOAD) ? idx_q : '0;
        last_word   = wr_en && st_q == ST_LOAD && idx_q == IDX_W'(PAGE_WORDS - 1);
        pv_ok       = st_q == ST_PV && pv_done && pv_pass;
        pv_bad      = st_q == ST_PV && pv_done && !pv_pass;
        adv         = pv_ok;
        flags       = '{ready: st_q == ST_IDLE, err: err_q, pvbusy: st_q == ST_PV};
        status      = status_code(flags);
    end

    assign pv_req = req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            idx_q   <= '0;
            retry_q <= '0;
            err_q   <= 1'b0;
            req_q   <= 1'b0;
        end else begin
            req_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: if (start) begin
                    st_q  <= ST_FIRST;
                    err_q <= 1'b0;
                end
                ST_FIRST: if (latch_start) begin
                    st_q  <= ST_LOAD;
                    idx_q <= IDX_W'(1);
                end
                ST_WAIT: begin
                    if (latch_page) begin
                        st_q  <= ST_LOAD;
                        idx_q <= IDX_W'(1);
                    end else if (term) begin
                        st_q <= ST_IDLE;
                    end
                end
                ST_LOAD: if (wr_en) begin
                    idx_q <= idx_q + IDX_W'(1);
                    if (last_word) begin
                        st_q    <= ST_PV;
                        req_q   <= 1'b1;
                        retry_q <= '0;
                    end
                end
                ST_PV: begin
                    if (pv_ok) begin
                        st_q <= ST_WAIT;
                    end else if (pv_bad) begin
                        if (retry_q == RW'(MAX_RETRY)) begin
                            err_q <= 1'b1;
                            st_q  <= ST_IDLE;
                        end else begin
                            retry_q <= retry_q + RW'(1);
                            req_q   <= 1'b1;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/quadword_prog_seq.sv
module quadword_prog_seq #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int BLK_BITS  = 8,
    parameter int MAX_RETRY = 2,
    localparam int WORDS    = qpp_pkg::PAGE_WORDS,
    localparam int PAGE_W   = DATA_W * WORDS,
    localparam int IDX_W    = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pv_req,
    output logic [ADDR_W-1:0] pv_addr,
    output logic [PAGE_W-1:0] pv_data,
    input  logic              pv_done,
    input  logic              pv_pass,
    output logic [7:0]        status
);
    logic             latch_start, latch_page, buf_we, adv, in_blk;
    logic [IDX_W-1:0] buf_idx;

    qpp_ctrl #(.DATA_W(DATA_W), .MAX_RETRY(MAX_RETRY)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .wr_en(wr_en), .wr_data(wr_data),
        .in_blk(in_blk), .pv_done(pv_done), .pv_pass(pv_pass),
        .latch_start(latch_start), .latch_page(latch_page), .buf_we(buf_we),
        .buf_idx(buf_idx), .adv(adv), .pv_req(pv_req), .status(status)
    );

    qpp_addr_gen #(.ADDR_W(ADDR_W), .BLK_BITS(BLK_BITS)) u_addr (
        .clk(clk), .rst(rst), .latch_start(latch_start), .latch_page(latch_page),
        .adv(adv), .wr_addr(wr_addr), .in_blk(in_blk), .page_base(pv_addr)
    );

    qpp_page_buf #(.DATA_W(DATA_W), .WORDS(WORDS)) u_buf (
        .clk(clk), .rst(rst), .we(buf_we), .idx(buf_idx), .din(wr_data), .page(pv_data)
    );
endmodule

// File: rtl/qpp_seq_chk.sv
module qpp_seq_chk #(
    parameter int PAGE_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              pv_req,
    input logic [PAGE_W-1:0] pv_data,
    input logic [7:0]        status
);
    // R5
    pv_start_req_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status[0]) |-> pv_req);
    // R5
    req_in_pv_chk: assert property (@(posedge clk) disable iff (rst)
        pv_req |-> status[0]);
    // R1
    ready_busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(status[7] && status[0]));
    // R6
    pv_data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (status[0] && $past(status[0])) |-> $stable(pv_data));
    // R10
    err_ready_chk: assert property (@(posedge clk) disable iff (rst)
        status[4] |-> status[7]);
    // R2
    start_enter_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(start) && $past(status[7])) |-> (!status[7] && !status[4]));
endmodule

bind quadword_prog_seq qpp_seq_chk #(.PAGE_W(PAGE_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .pv_req(pv_req),
    .pv_data(pv_data), .status(status)
);

// File: tb/quadword_prog_seq_tb_top.sv
module quadword_prog_seq_tb_top;
    localparam logic [15:0] S  = 16'h3A10;
    localparam logic [15:0] OB = 16'h5B00;

    logic        clk = 0, rst = 1, start = 0, wr_en = 0, pv_done = 0, pv_pass = 0;
    logic [15:0] wr_addr = 0, wr_data = 0, pv_addr;
    logic [63:0] pv_data;
    logic [7:0]  status;
    logic        pv_req;
    int          checks = 0, fails = 0;
    logic [15:0] ptr;
    logic [15:0] d[4];

    always #5 clk = ~clk;

    quadword_prog_seq dut_i (
        .clk(clk), .rst(rst), .start(start), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pv_req(pv_req), .pv_addr(pv_addr), .pv_data(pv_data),
        .pv_done(pv_done), .pv_pass(pv_pass), .status(status)
    );

    function automatic logic [15:0] nxt(input logic [15:0] p);
        return {p[15:8], p[7:0] + 8'd4};
    endfunction

    function automatic logic [63:0] packed_page();
        return {d[3], d[2], d[1], d[0]};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bwrite(input logic [15:0] a, input logic [15:0] v);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = v;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask

    // first write at a0, words 1..3 at an out-of-block address (ignored)
    task automatic page(input logic [15:0] a0, input logic [15:0] base, input string tag);
        bwrite(a0, d[0]);
        for (int k = 1; k < 4; k++) bwrite(OB + 16'(k), d[k]);
        chk({tag, " R5 req"}, 64'(pv_req), 64'd1);
        chk({tag, " R5 status"}, 64'(status), 64'h01);
        chk({tag, " R8 addr"}, 64'(pv_addr), 64'(base));
        chk({tag, " R4 data"}, pv_data, packed_page());
    endtask

    task automatic respond(input logic p, input logic with_wr);
        @(negedge clk); pv_done = 1; pv_pass = p;
        if (with_wr) begin wr_en = 1; wr_addr = S + 16'h0040; wr_data = 16'hBEEF; end
        @(negedge clk); pv_done = 0; wr_en = 0;
    endtask

    task automatic rand_data();
        for (int k = 0; k < 4; k++) d[k] = 16'($urandom);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 reset status", 64'(status), 64'h80);

        pulse_start();
        chk("R2 entered", 64'(status), 64'h00);

        rand_data();
        page(S, S, "R3 page1");
        bwrite(S, 16'h1234);
        bwrite(OB, 16'hFFFF);
        chk("R6 data held", pv_data, packed_page());
        chk("R6 status held", 64'(status), 64'h01);
        respond(1, 0);
        chk("R7 pass status", 64'(status), 64'h00);
        ptr = nxt(S);

        pulse_start();
        bwrite(OB + 16'h20, 16'h0001);
        chk("R9 ignored non-ones", 64'(status), 64'h00);

        rand_data(); d[3] = 16'hFFFF;
        page(S, ptr, "R2 R7 R4 page2");
        respond(0, 0);
        chk("R10 retry req", 64'(pv_req), 64'd1);
        chk("R10 retry status", 64'(status), 64'h01);
        respond(1, 0);
        chk("R7 pass2", 64'(status), 64'h00);
        ptr = nxt(ptr);

        rand_data();
        page(16'h3A80, 16'h3A80, "R8 page3");
        respond(1, 1);
        chk("R6 coincident status", 64'(status), 64'h00);
        chk("R6 coincident data", pv_data, packed_page());
        ptr = nxt(ptr);

        for (int i = 0; i < 24; i++) begin
            logic [15:0] a, b;
            int nf;
            rand_data();
            a = ($urandom % 3 == 0) ? S : {8'h3A, 8'($urandom)};
            b = (a == S) ? ptr : a;
            page(a, b, "R8 random");
            nf = $urandom % 3;
            for (int f = 0; f < nf; f++) begin
                respond(0, 0);
                chk("R10 random retry", 64'(pv_req), 64'd1);
            end
            respond(1, 0);
            chk("R7 random pass", 64'(status), 64'h00);
            ptr = nxt(ptr);
        end

        bwrite(OB + 16'h44, 16'hFFFF);
        chk("R9 exit", 64'(status), 64'h80);

        pulse_start();
        rand_data();
        page(16'h7000, 16'h7000, "R3 err page");
        respond(0, 0);
        respond(0, 0);
        chk("R10 last retry req", 64'(pv_req), 64'd1);
        respond(0, 0);
        chk("R10 error exit", 64'(status), 64'h90);
        chk("R10 no req", 64'(pv_req), 64'd0);
        bwrite(16'h7000, 16'hFFFF);
        chk("R11 sticky", 64'(status), 64'h90);
        pulse_start();
        chk("R11 cleared", 64'(status), 64'h00);
        rand_data();
        page(16'h7004, 16'h7004, "R3 after err");
        respond(1, 0);
        bwrite(16'h0000, 16'hFFFF);
        chk("R9 final exit", 64'(status), 64'h80);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule